// File: doc/BRIEF.md
# Dual-Mode Integer Multiply-Divide Unit

This block executes signed and unsigned integer multiply, divide and remainder on 64-bit operands. A word-size select picks either full 64-bit arithmetic or arithmetic on the low 32-bit words. Every 32-bit result is sign-extended to 64 bits. Multiply is a single-cycle operation. Divide is iterative and retires one quotient bit per cycle, so it holds `busy_o` while it runs.

Two result models share one datapath. In the classic model, each operation writes a pair of internal result registers:
- the high product half or the remainder goes to HI;
- the low product half or the quotient goes to LO.

Both registers are always readable. In the newer model, a 5-bit selector picks one of the four values instead. That value appears on `result_o` with a one-cycle destination write strobe. HI and LO are left untouched. A selector code the unit does not know raises a one-cycle unimplemented flag and writes nothing.

Divide has defined behaviour for two corner cases. The most-negative-by-minus-one case gives the most negative value as quotient and zero as remainder. A zero divisor writes no result at all.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `dst_we_o` and `unimpl_o` are low, and `hi_o`, `lo_o` and `result_o` are zero.
- R2: With `op_i` 0 (signed multiply) or 1 (unsigned multiply) and `wide_i`=0, the unit forms the exact 64-bit product of the low 32-bit words of the two operands. The low words are sign-extended for op 0 and zero-extended for op 1. In classic mode (`mode_i`=0), product bits 31:0 go to LO and bits 63:32 go to HI, each sign-extended to 64 bits. `done_o` pulses in the cycle after the start is accepted, and `busy_o` stays low.
- R3: With `wide_i`=1, a multiply forms the full 128-bit product. In classic mode, bits 127:64 go to HI and bits 63:0 go to LO.
- R4: In the newer mode (`mode_i`=1), a multiply with `sub_i`=2 puts the low half on `result_o`, and `sub_i`=3 puts the high half on `result_o`. In both cases `dst_we_o` pulses together with `done_o`, and HI and LO keep their values. `dst_we_o` never rises for a classic-mode operation.
- R5: In the newer mode, any `sub_i` value other than 2 or 3 gives an `unimpl_o` pulse with `done_o`. It writes neither HI, LO nor the destination.
- R6: With `op_i` 2 (signed divide) or 3 (unsigned divide) in classic mode, the quotient goes to LO and the remainder goes to HI. The signed quotient truncates toward zero, and the signed remainder takes the sign of the dividend.
- R7: A signed divide of the most negative value (for the selected width) by -1 gives the most negative value as quotient and 0 as remainder, in both widths and both modes.
- R8: In the newer mode, a divide with `sub_i`=2 puts the quotient on `result_o`, and `sub_i`=3 puts the remainder on `result_o`.
- R9: A divide whose divisor is zero is decided by the low 32 bits when `wide_i`=0. It writes neither HI, LO nor the destination, and it completes with `done_o` in the cycle after acceptance without raising `busy_o`.
- R10: A divide with a nonzero divisor holds `busy_o` for 65 cycles when `wide_i`=1 and for 33 cycles when `wide_i`=0. `done_o` pulses for one cycle as `busy_o` falls, and `busy_o` and `done_o` are never high together.
- R11: A `start_i` pulse while `busy_o` is high is ignored. The running divide keeps its operands, and the ignored request produces no completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; accepted when `busy_o` is low |
| op_i | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| wide_i | input | 1 | 1: 64-bit operation, 0: 32-bit on low words |
| mode_i | input | 1 | 0: classic HI/LO model, 1: single-result model |
| sub_i | input | 5 | Result selector in the single-result model (2 low/quotient, 3 high/remainder) |
| opa_i | input | 64 | First operand / dividend |
| opb_i | input | 64 | Second operand / divisor |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dst_we_o | output | 1 | Destination write strobe for `result_o` |
| unimpl_o | output | 1 | Unknown selector in the single-result model |
| result_o | output | 64 | Last single-model result |
| hi_o | output | 64 | HI register |
| lo_o | output | 64 | LO register |

## Verification
Some properties are checked on every cycle:
- the busy/done exclusion and the exact busy length of each divide;
- that HI and LO stay frozen while a divide runs and after an unknown selector or a zero divisor;
- that the destination strobe appears only at completion of a newer-mode operation.

The arithmetic values cannot be checked that way. The bench computes products, quotients and remainders from the requirements and compares them against the outputs. Its scenarios also cover the signed corner operands, zero divisors whose upper word is nonzero, and a start request arriving mid-divide.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } md_op_e;

  // single-result selector codes, decoded by the issuing pipeline as well
  localparam logic [4:0] SUB_LOW  = 5'd2;
  localparam logic [4:0] SUB_HIGH = 5'd3;
endpackage

// File: rtl/md_mult.sv
`timescale 1ns/1ps
module md_mult #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  input  logic         wide_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;

  // extend an operand to the double-width product domain
  function automatic logic [PW-1:0] ext_op(input logic [W-1:0] x, input logic sgn,
                                           input logic wide);
    logic [PW-1:0] r;
    if (wide) r = {{W{sgn & x[W-1]}}, x};
    else      r = {{(PW-H){sgn & x[H-1]}}, x[H-1:0]};
    return r;
  endfunction

  function automatic logic [W-1:0] sx_half(input logic [H-1:0] v);
    return {{H{v[H-1]}}, v};
  endfunction

  logic [PW-1:0] prod_w;

  always_comb begin
    prod_w = ext_op(a_i, sgn_i, wide_i) * ext_op(b_i, sgn_i, wide_i);
    if (wide_i) begin
      lo_o = prod_w[W-1:0];
      hi_o = prod_w[PW-1:W];
    end else begin
      lo_o = sx_half(prod_w[H-1:0]);
      hi_o = sx_half(prod_w[W-1:H]);
    end
  end
endmodule

// File: rtl/md_div.sv
`timescale 1ns/1ps
module md_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic         wide_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W + 1);

  function automatic logic [W-1:0] widen(input logic [W-1:0] x, input logic sgn,
                                         input logic wide);
    if (wide) return x;
    return {{H{sgn & x[H-1]}}, x[H-1:0]};
  endfunction

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic neg);
    return neg ? (~v + {{(W-1){1'b0}}, 1'b1}) : v;
  endfunction

  function automatic logic [W-1:0] finish(input logic [W-1:0] raw, input logic neg,
                                          input logic wide);
    logic [W-1:0] s;
    s = magnitude(raw, neg);
    if (wide) return s;
    return {{H{s[H-1]}}, s[H-1:0]};
  endfunction

  logic          busy_q, negq_q, negr_q, wide_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [W-1:0]  av_w, bv_w, amag_w;
  logic          an_w, bn_w;
  logic [W:0]    trial_w;
  logic          ge_w;
  logic [W-1:0]  rem_next_w;
  logic [W-1:0]  qraw_w, rraw_w;

  always_comb begin
    av_w       = widen(a_i, sgn_i, wide_i);
    bv_w       = widen(b_i, sgn_i, wide_i);
    an_w       = sgn_i & av_w[W-1];
    bn_w       = sgn_i & bv_w[W-1];
    amag_w     = magnitude(av_w, an_w);
    trial_w    = {rem_q, quo_q[W-1]};
    ge_w       = trial_w >= {1'b0, den_q};
    rem_next_w = ge_w ? (trial_w[W-1:0] - den_q) : trial_w[W-1:0];
    qraw_w     = wide_q ? quo_q : {{H{1'b0}}, quo_q[H-1:0]};
    rraw_w     = wide_q ? rem_q : {{H{1'b0}}, rem_q[H-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      wide_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      negq_q <= an_w ^ bn_w;
      negr_q <= an_w;
      wide_q <= wide_i;
      cnt_q  <= wide_i ? CW'(W) : CW'(H);
      rem_q  <= '0;
      quo_q  <= wide_i ? amag_w : (amag_w << H);
      den_q  <= magnitude(bv_w, bn_w);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        rem_q <= rem_next_w;
        quo_q <= {quo_q[W-2:0], ge_w};
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == '0);
  assign quo_o  = finish(qraw_w, negq_q, wide_q);
  assign rem_o  = finish(rraw_w, negr_q, wide_q);
endmodule

// File: rtl/md_wb.sv
`timescale 1ns/1ps
module md_wb
  import muldiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mul_ev_i,
  input  logic         div_ev_i,
  input  logic         dz_ev_i,
  input  logic         mode_i,
  input  logic [4:0]   sub_i,
  input  logic [W-1:0] mlo_i,
  input  logic [W-1:0] mhi_i,
  input  logic [W-1:0] dq_i,
  input  logic [W-1:0] dr_i,
  output logic         done_o,
  output logic         dst_we_o,
  output logic         unimpl_o,
  output logic [W-1:0] result_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic         any_w, res_w, sub_ok_w;
  logic [W-1:0] lo_n_w, hi_n_w;

  always_comb begin
    any_w    = mul_ev_i | div_ev_i | dz_ev_i;
    res_w    = mul_ev_i | div_ev_i;
    sub_ok_w = (sub_i == SUB_LOW) || (sub_i == SUB_HIGH);
    lo_n_w   = mul_ev_i ? mlo_i : dq_i;
    hi_n_w   = mul_ev_i ? mhi_i : dr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      dst_we_o <= 1'b0;
      unimpl_o <= 1'b0;
      result_o <= '0;
      hi_o     <= '0;
      lo_o     <= '0;
    end else begin
      done_o   <= any_w;
      dst_we_o <= res_w & mode_i & sub_ok_w;
      unimpl_o <= any_w & mode_i & ~sub_ok_w;
      if (res_w && !mode_i) begin
        hi_o <= hi_n_w;
        lo_o <= lo_n_w;
      end
      if (res_w && mode_i && sub_ok_w)
        result_o <= (sub_i == SUB_LOW) ? lo_n_w : hi_n_w;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic         wide_i,
  input  logic         mode_i,
  input  logic [4:0]   sub_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dst_we_o,
  output logic         unimpl_o,
  output logic [W-1:0] result_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int H = W / 2;

  // named events, also observed by the bound checker
  logic accept_w, is_div_w, sgn_w, divisor_zero_w;
  logic mul_ev_w, div_go_w, div_zero_w, fin_w;
  logic mode_q, sel_mode_w;
  logic [4:0] sub_q, sel_sub_w;
  logic [W-1:0] mlo_w, mhi_w, dq_w, dr_w;

  always_comb begin
    accept_w       = start_i & ~busy_o;
    is_div_w       = (op_i == OP_DIVS) || (op_i == OP_DIVU);
    sgn_w          = (op_i == OP_MULS) || (op_i == OP_DIVS);
    divisor_zero_w = wide_i ? (opb_i == '0) : (opb_i[H-1:0] == '0);
    mul_ev_w       = accept_w & ~is_div_w;
    div_go_w       = accept_w & is_div_w & ~divisor_zero_w;
    div_zero_w     = accept_w & is_div_w & divisor_zero_w;
    sel_mode_w     = fin_w ? mode_q : mode_i;
    sel_sub_w      = fin_w ? sub_q : sub_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sub_q  <= '0;
    end else if (accept_w) begin
      mode_q <= mode_i;
      sub_q  <= sub_i;
    end
  end

  md_mult #(.W(W)) u_mult (
    .a_i(opa_i), .b_i(opb_i), .sgn_i(sgn_w), .wide_i(wide_i),
    .lo_o(mlo_w), .hi_o(mhi_w)
  );

  md_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_go_w), .sgn_i(sgn_w), .wide_i(wide_i),
    .a_i(opa_i), .b_i(opb_i), .busy_o(busy_o), .fin_o(fin_w),
    .quo_o(dq_w), .rem_o(dr_w)
  );

  md_wb #(.W(W)) u_wb (
    .clk(clk), .rst_n(rst_n), .mul_ev_i(mul_ev_w), .div_ev_i(fin_w),
    .dz_ev_i(div_zero_w), .mode_i(sel_mode_w), .sub_i(sel_sub_w),
    .mlo_i(mlo_w), .mhi_i(mhi_w), .dq_i(dq_w), .dr_i(dr_w),
    .done_o(done_o), .dst_we_o(dst_we_o), .unimpl_o(unimpl_o),
    .result_o(result_o), .hi_o(hi_o), .lo_o(lo_o)
  );
endmodule

// File: rtl/md_checker.sv
`timescale 1ns/1ps
module md_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         wide_i,
  input logic         mode_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         dst_we_o,
  input logic         unimpl_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o,
  input logic         fin_w,
  input logic         div_zero_w
);
  localparam int CW = $clog2(W + 2);

  logic [CW-1:0] busy_cnt;
  logic          wide_c, mode_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      wide_c   <= 1'b0;
      mode_c   <= 1'b0;
    end else begin
      busy_cnt <= busy_o ? busy_cnt + 1'b1 : '0;
      if (start_i && !busy_o) begin
        wide_c <= wide_i;
        mode_c <= mode_i;
      end
    end
  end

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_div_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o && (busy_cnt == (wide_c ? CW'(W + 1) : CW'(W / 2 + 1))));

  assert_dst_newmode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we_o |-> done_o && mode_c);

  assert_unimpl_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_o |-> done_o && !dst_we_o && $stable(hi_o) && $stable(lo_o));

  assert_zero_divisor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero_w |=> done_o && !dst_we_o && $stable(hi_o) && $stable(lo_o));

  assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !fin_w |=> $stable(hi_o) && $stable(lo_o) && !done_o);
endmodule

bind muldiv_unit md_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i), .mode_i(mode_i),
  .busy_o(busy_o), .done_o(done_o), .dst_we_o(dst_we_o), .unimpl_o(unimpl_o),
  .hi_o(hi_o), .lo_o(lo_o), .fin_w(fin_w), .div_zero_w(div_zero_w)
);

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        wide = 1'b0, mode = 1'b0;
  logic [4:0]  sub = 5'd0;
  logic [63:0] a = '0, b = '0;
  logic        busy_o, done_o, dst_we_o, unimpl_o;
  logic [63:0] result_o, hi_o, lo_o;

  int nchk = 0, nfail = 0;
  logic [63:0] hi_m = '0, lo_m = '0;

  always #2.5 clk = ~clk;

  muldiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .mode_i(mode), .sub_i(sub), .opa_i(a), .opb_i(b), .busy_o(busy_o),
    .done_o(done_o), .dst_we_o(dst_we_o), .unimpl_o(unimpl_o),
    .result_o(result_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // reference results in HI/LO terms: elo = low/quotient, ehi = high/remainder
  task automatic model(input logic [1:0] o, input bit w, input logic [63:0] x,
                       input logic [63:0] y, output logic [63:0] elo,
                       output logic [63:0] ehi, output bit zero);
    bit sgn = (o == 2'd0) || (o == 2'd2);
    zero = 1'b0;
    if (o < 2) begin
      if (!w) begin
        longint px, py, pp;
        px = sgn ? longint'($signed(x[31:0])) : longint'({32'b0, x[31:0]});
        py = sgn ? longint'($signed(y[31:0])) : longint'({32'b0, y[31:0]});
        pp = px * py;
        elo = sx32(pp[31:0]);
        ehi = sx32(pp[63:32]);
      end else begin
        logic [127:0] pu;
        pu = {64'b0, x} * {64'b0, y};
        elo = pu[63:0];
        ehi = pu[127:64];
        if (sgn) ehi = ehi - (x[63] ? y : 64'd0) - (y[63] ? x : 64'd0);
      end
    end else begin
      elo = '0; ehi = '0;
      if (!w) begin
        zero = (y[31:0] == 32'd0);
        if (!zero) begin
          if (sgn) begin
            int sx = int'(x[31:0]), sy = int'(y[31:0]), q, r;
            if (sx == 32'sh80000000 && sy == -1) begin q = sx; r = 0; end
            else begin q = sx / sy; r = sx % sy; end
            elo = sx32(q); ehi = sx32(r);
          end else begin
            elo = sx32(x[31:0] / y[31:0]);
            ehi = sx32(x[31:0] % y[31:0]);
          end
        end
      end else begin
        zero = (y == 64'd0);
        if (!zero) begin
          if (sgn) begin
            longint sx = longint'(x), sy = longint'(y);
            if (x == 64'h8000000000000000 && sy == -1) begin elo = x; ehi = '0; end
            else begin elo = sx / sy; ehi = sx % sy; end
          end else begin
            elo = x / y; ehi = x % y;
          end
        end
      end
    end
  endtask

  task automatic do_op(input logic [1:0] o, input bit w, input bit m, input logic [4:0] s,
                       input logic [63:0] x, input logic [63:0] y, input string req);
    logic [63:0] elo, ehi;
    bit zero, ok_sub;
    int bcyc = 0, waited = 0;
    @(negedge clk);
    op = o; wide = w; mode = m; sub = s; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done_o && waited < 200) begin
      if (busy_o) bcyc++;
      @(negedge clk);
      waited++;
    end
    check(req, "done seen", {63'b0, done_o}, 64'd1);
    model(o, w, x, y, elo, ehi, zero);
    ok_sub = (s == 5'd2) || (s == 5'd3);
    if (o >= 2 && !zero)
      check("R10", "busy cycles", 64'(bcyc), w ? 64'd65 : 64'd33);
    else
      check(zero ? "R9" : "R2", "busy cycles", 64'(bcyc), 64'd0);
    if (m && !ok_sub) begin
      check("R5", "unimpl", {63'b0, unimpl_o}, 64'd1);
      check("R5", "dst_we", {63'b0, dst_we_o}, 64'd0);
    end else if (zero) begin
      check("R9", "dst_we", {63'b0, dst_we_o}, 64'd0);
    end else if (!m) begin
      hi_m = ehi; lo_m = elo;
      check(req, "dst_we", {63'b0, dst_we_o}, 64'd0);
    end else begin
      check(req, "dst_we", {63'b0, dst_we_o}, 64'd1);
      check(req, "result", result_o, (s == 5'd2) ? elo : ehi);
    end
    check(req, "hi", hi_o, hi_m);
    check(req, "lo", lo_o, lo_m);
  endtask

  function automatic string pick_req(input logic [1:0] o, input bit w, input bit m,
                                     input logic [4:0] s, input logic [63:0] y);
    bit zero = w ? (y == 0) : (y[31:0] == 0);
    if (m && !(s == 5'd2 || s == 5'd3)) return "R5";
    if (o >= 2) begin
      if (zero) return "R9";
      return m ? "R8" : "R6";
    end
    if (m) return "R4";
    return w ? "R3" : "R2";
  endfunction

  localparam logic [63:0] MIN64 = 64'h8000000000000000;
  localparam logic [63:0] MIN32 = 64'h0000000080000000;
  localparam logic [63:0] NEG1  = 64'hFFFFFFFFFFFFFFFF;

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", {63'b0, busy_o}, 64'd0);
    check("R1", "done", {63'b0, done_o}, 64'd0);
    check("R1", "dst_we/unimpl", {62'b0, dst_we_o, unimpl_o}, 64'd0);
    check("R1", "hi", hi_o, 64'd0);
    check("R1", "lo", lo_o, 64'd0);
    check("R1", "result", result_o, 64'd0);

    // R2 narrow multiply, upper operand words are don't-care
    do_op(2'd0, 0, 0, 5'd0, 64'hDEAD0000FFFFFFFD, 64'h1234000000000007, "R2");
    do_op(2'd1, 0, 0, 5'd0, 64'h00000000FFFFFFFF, 64'hFFFFFFFFFFFFFFFF, "R2");
    do_op(2'd0, 0, 0, 5'd0, MIN32, MIN32, "R2");
    // R3 wide multiply
    do_op(2'd0, 1, 0, 5'd0, MIN64, MIN64, "R3");
    do_op(2'd1, 1, 0, 5'd0, NEG1, NEG1, "R3");
    do_op(2'd0, 1, 0, 5'd0, NEG1, 64'd5, "R3");
    // R4 single-result multiply
    do_op(2'd0, 1, 1, 5'd2, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, "R4");
    do_op(2'd0, 1, 1, 5'd3, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, "R4");
    do_op(2'd1, 0, 1, 5'd3, 64'hFFFFFFFF, 64'hFFFFFFFF, "R4");
    // R5 unknown selector
    do_op(2'd0, 1, 1, 5'd0, 64'd9, 64'd9, "R5");
    do_op(2'd2, 1, 1, 5'd31, 64'd100, 64'd7, "R5");
    // R6 classic divide
    do_op(2'd2, 0, 0, 5'd0, 64'hFFFFFFF9, 64'd2, "R6");
    do_op(2'd2, 0, 0, 5'd0, 64'd7, 64'hFFFFFFFE, "R6");
    do_op(2'd2, 1, 0, 5'd0, 64'hFFFFFFFFFFFFFF9C, 64'd7, "R6");
    do_op(2'd3, 1, 0, 5'd0, NEG1, 64'd3, "R6");
    do_op(2'd3, 0, 0, 5'd0, 64'hFFFFFFFF, 64'd1, "R6");
    // R7 most negative by minus one
    do_op(2'd2, 1, 0, 5'd0, MIN64, NEG1, "R7");
    do_op(2'd2, 0, 0, 5'd0, MIN32, 64'hFFFFFFFF, "R7");
    do_op(2'd2, 1, 1, 5'd2, MIN64, NEG1, "R7");
    do_op(2'd2, 1, 1, 5'd3, MIN64, NEG1, "R7");
    // R8 single-result divide
    do_op(2'd2, 1, 1, 5'd2, 64'hFFFFFFFFFFFFFC18, 64'd33, "R8");
    do_op(2'd2, 1, 1, 5'd3, 64'hFFFFFFFFFFFFFC18, 64'd33, "R8");
    // R9 zero divisor, narrow zero decided by low word
    do_op(2'd2, 1, 0, 5'd0, 64'd55, 64'd0, "R9");
    do_op(2'd3, 0, 0, 5'd0, 64'd55, 64'hABCD000000000000, "R9");
    do_op(2'd2, 1, 1, 5'd2, 64'd55, 64'd0, "R9");

    // R11 start while busy is ignored
    begin
      logic [63:0] elo, ehi;
      bit zero;
      int waited = 0;
      @(negedge clk);
      op = 2'd3; wide = 1; mode = 0; sub = 0; a = 64'd1000; b = 64'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      op = 2'd0; a = 64'd3; b = 64'd3; mode = 1; sub = 5'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0; a = 64'd1; b = 64'd1;
      while (!done_o && waited < 200) begin @(negedge clk); waited++; end
      model(2'd3, 1, 64'd1000, 64'd7, elo, ehi, zero);
      hi_m = ehi; lo_m = elo;
      check("R11", "lo after ignored start", lo_o, elo);
      check("R11", "hi after ignored start", hi_o, ehi);
      check("R11", "dst_we", {63'b0, dst_we_o}, 64'd0);
      repeat (4) begin
        @(negedge clk);
        check("R11", "no extra done", {63'b0, done_o}, 64'd0);
      end
    end

    // constrained random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 300; i++) begin
      logic [1:0] o = 2'($urandom % 4);
      bit w = 1'($urandom % 2);
      bit m = 1'($urandom % 2);
      int sel = $urandom % 8;
      logic [4:0] s = (sel < 3) ? 5'd2 : (sel < 6) ? 5'd3 : 5'($urandom);
      logic [63:0] x = {$urandom, $urandom};
      logic [63:0] y = {$urandom, $urandom};
      int shape = $urandom % 6;
      if (shape == 0) y = 64'(y[7:0]);
      if (shape == 1) y = {$urandom, 32'(y[3:0])};
      if (shape == 2) x = 64'($signed(x[15:0]));
      if (shape == 3) y = NEG1;
      do_op(o, w, m, s, x, y, pick_req(o, w, m, s, y));
    end

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule